// File: doc/BRIEF.md
# Speed-Expansion Arrival Window Checker

This block sits beside the input ports of a switch that can gang ports together to raise the line rate. Each port raises a one-cycle packet-start strobe on the shared byte clock. A mode bit selects the port arrangement. When the mode bit is low, every port runs on its own at the base rate and the block stays silent. When the mode bit is high, the lower half of the ports become masters and the upper half become slaves. Port `g` is paired with port `g + NUM_PORTS/2`.

The master's start cycle is the reference cycle Ta for its pair. The slave may start in any of three cycles: Ta-1, Ta or Ta+1.

- If the pair starts inside that window, the block raises a one-cycle "aligned" pulse for the group.
- If the pair misses the window, the block raises a one-cycle "violation" pulse. Alongside it, the block gives the index of the port that failed to arrive in time.

Each group is tracked on its own. The block only observes the strobes. It does not hold, route or realign any packet data.

Top module: `spx_window_chk`

## Requirements
- R1: While `pair_mode_i` is 0, `aligned_o` and `viol_o` stay all zero and no start is remembered across cycles.
- R2: While `pair_mode_i` is 1, group `g` (0 to NUM_PORTS/2-1) is formed by master port `g` and slave port `g+NUM_PORTS/2`; starts on two ports of different groups never match each other.
- R3: A master start and a slave start in the same cycle T give `aligned_o[g]` = 1 in cycle T+1.
- R4: A slave start one cycle after its master start (cycle Ta+1) gives `aligned_o[g]` = 1 in cycle Ta+2.
- R5: A slave start one cycle before its master start (cycle Ta-1) is held, and gives `aligned_o[g]` = 1 in cycle Ta+1.
- R6: A master start at Ta with no slave start at Ta or Ta+1 (and none held from Ta-1) gives `viol_o[g]` = 1 in cycle Ta+2, with the port field of group `g` equal to `g+NUM_PORTS/2`, the slave index.
- R7: A slave start at Ts with no master start at Ts or Ts+1 (and no master held from Ts-1) gives `viol_o[g]` = 1 in cycle Ts+2, with the port field equal to `g`, the master index.
- R8: The aligned and violation outputs are single-cycle pulses per decision. A group never shows both in one cycle. The port field of group `g` occupies bits `[g*PORT_W +: PORT_W]` of `viol_port_o`, and reads 0 when `viol_o[g]` is 0.
- R9: Each group is judged only from its own two strobes, so events in different groups in the same cycles do not interfere.
- R10: An asserted `rst_ni` drops all held starts and clears every output to 0. No decision on a start seen before the reset appears afterwards.
- R11: A start used in a match is consumed. A held master that matches a slave cannot also pair with a later master, and a fresh start in the same cycle opens its own window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pair_mode_i | input | 1 | 0: independent ports, 1: paired ports with window check |
| start_i | input | NUM_PORTS | One-cycle packet-start strobe per port |
| aligned_o | output | NUM_PORTS/2 | Per-group pulse: pair started inside the window |
| viol_o | output | NUM_PORTS/2 | Per-group pulse: pair missed the window |
| viol_port_o | output | NUM_PORTS/2*PORT_W | Per-group index of the port that failed to arrive in time |

## Verification
The pairing is tried at each legal skew (-1, 0 and +1 cycle), which separates a working hold of an early slave from a design that only matches within the same cycle. Stimulus at skew 2, and a lone strobe on either side of a pair, separate master-timeout from slave-timeout reporting and check the port index. Back-to-back masters with a slave between them show whether a matched start is consumed. Starts on two non-paired ports show the pairing map. A pseudo-random burst across all groups, and the same strobes with the mode bit low, check group independence and the silent mode. A reset issued while a start is held shows that no stale decision survives it.

// File: rtl/spx_win_pkg.sv
package spx_win_pkg;

  typedef enum logic [1:0] {
    GRP_IDLE  = 2'd0,
    GRP_MWAIT = 2'd1,
    GRP_SWAIT = 2'd2
  } grp_state_e;

  typedef struct packed {
    logic aligned;
    logic viol;
    logic viol_slave;  // 1: slave missing, 0: master missing
  } grp_evt_t;

endpackage

// File: rtl/spx_pair_tracker.sv
module spx_pair_tracker
  import spx_win_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     mst_start_i,
  input  logic     slv_start_i,
  output grp_evt_t evt_o
);

  grp_state_e state_q, state_d;
  logic       mst_left, slv_left;

  always_comb begin
    evt_o    = '0;
    state_d  = GRP_IDLE;
    mst_left = mst_start_i;
    slv_left = slv_start_i;
    if (en_i) begin
      // resolve the start held from the previous cycle first
      unique case (state_q)
        GRP_MWAIT: begin
          if (slv_start_i) begin
            evt_o.aligned = 1'b1;
            slv_left      = 1'b0;
          end else begin
            evt_o.viol       = 1'b1;
            evt_o.viol_slave = 1'b1;
          end
        end
        GRP_SWAIT: begin
          if (mst_start_i) begin
            evt_o.aligned = 1'b1;
            mst_left      = 1'b0;
          end else begin
            evt_o.viol       = 1'b1;
            evt_o.viol_slave = 1'b0;
          end
        end
        default: ;
      endcase
      // unconsumed starts of this cycle
      if (mst_left && slv_left) begin
        evt_o.aligned = 1'b1;
      end else if (mst_left) begin
        state_d = GRP_MWAIT;
      end else if (slv_left) begin
        state_d = GRP_SWAIT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= GRP_IDLE;
    else         state_q <= state_d;
  end

endmodule

// File: rtl/spx_evt_reg.sv
module spx_evt_reg
  import spx_win_pkg::*;
#(
  parameter int unsigned PORT_W  = 4,
  parameter int unsigned MST_IDX = 0,
  parameter int unsigned SLV_IDX = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  grp_evt_t          evt_i,
  output logic              aligned_o,
  output logic              viol_o,
  output logic [PORT_W-1:0] port_o
);

  localparam logic [PORT_W-1:0] MstIdx = PORT_W'(MST_IDX);
  localparam logic [PORT_W-1:0] SlvIdx = PORT_W'(SLV_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_o <= 1'b0;
      viol_o    <= 1'b0;
      port_o    <= '0;
    end else begin
      aligned_o <= evt_i.aligned;
      viol_o    <= evt_i.viol;
      port_o    <= !evt_i.viol ? '0 : (evt_i.viol_slave ? SlvIdx : MstIdx);
    end
  end

endmodule

// File: rtl/spx_window_chk.sv
module spx_window_chk
  import spx_win_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 16,
  localparam int unsigned NUM_GRP  = NUM_PORTS / 2,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pair_mode_i,
  input  logic [NUM_PORTS-1:0]      start_i,
  output logic [NUM_GRP-1:0]        aligned_o,
  output logic [NUM_GRP-1:0]        viol_o,
  output logic [NUM_GRP*PORT_W-1:0] viol_port_o
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    grp_evt_t evt;

    spx_pair_tracker u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (pair_mode_i),
      .mst_start_i (start_i[g]),
      .slv_start_i (start_i[g+NUM_GRP]),
      .evt_o       (evt)
    );

    spx_evt_reg #(
      .PORT_W  (PORT_W),
      .MST_IDX (g),
      .SLV_IDX (g + NUM_GRP)
    ) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt),
      .aligned_o (aligned_o[g]),
      .viol_o    (viol_o[g]),
      .port_o    (viol_port_o[g*PORT_W +: PORT_W])
    );
  end

endmodule

// File: rtl/spx_window_chk_sva.sv
module spx_window_chk_sva #(
  parameter int unsigned NUM_PORTS = 16,
  localparam int unsigned NUM_GRP  = NUM_PORTS / 2,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      pair_mode_i,
  input logic [NUM_PORTS-1:0]      start_i,
  input logic [NUM_GRP-1:0]        aligned_o,
  input logic [NUM_GRP-1:0]        viol_o,
  input logic [NUM_GRP*PORT_W-1:0] viol_port_o
);

  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    localparam logic [PORT_W-1:0] MstIdx = PORT_W'(g);
    localparam logic [PORT_W-1:0] SlvIdx = PORT_W'(g + NUM_GRP);
    logic [PORT_W-1:0] port;
    assign port = viol_port_o[g*PORT_W +: PORT_W];

    assert_silent_unpaired_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst != 2'd0 && !$past(pair_mode_i)) |-> (!aligned_o[g] && !viol_o[g]));

    assert_same_cycle_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst != 2'd0 && $past(pair_mode_i) && $past(start_i[g]) && $past(start_i[g+NUM_GRP]))
      |-> aligned_o[g]);

    assert_master_timeout_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (since_rst == 2'd3 && $past(pair_mode_i, 1) && $past(pair_mode_i, 2)
       && $past(start_i[g], 2) && !$past(start_i[g+NUM_GRP], 1)
       && !$past(start_i[g+NUM_GRP], 2) && !$past(start_i[g+NUM_GRP], 3))
      |-> (viol_o[g] && port == SlvIdx));

    assert_exclusive_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(aligned_o[g] && viol_o[g]));

    assert_port_in_group_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o[g] |-> (port == MstIdx || port == SlvIdx));

    assert_port_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !viol_o[g] |-> (port == '0));
  end

endmodule

bind spx_window_chk spx_window_chk_sva #(.NUM_PORTS(NUM_PORTS)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pair_mode_i (pair_mode_i),
  .start_i     (start_i),
  .aligned_o   (aligned_o),
  .viol_o      (viol_o),
  .viol_port_o (viol_port_o)
);

// File: tb/spx_window_chk_tb.sv
module spx_window_chk_tb;

  localparam int NP = 16;
  localparam int NG = NP / 2;
  localparam int PW = $clog2(NP);
  localparam int NONE = -100;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pair_mode_i = 1'b0;
  logic [NP-1:0] start_i = '0;
  logic [NG-1:0] aligned_o, viol_o;
  logic [NG*PW-1:0] viol_port_o;

  spx_window_chk #(.NUM_PORTS(NP)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pair_mode_i (pair_mode_i),
    .start_i     (start_i),
    .aligned_o   (aligned_o),
    .viol_o      (viol_o),
    .viol_port_o (viol_port_o)
  );

  always #4 clk_i = ~clk_i;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int now = 0;
  int m_t[NG];
  int s_t[NG];
  logic [NG-1:0]    exp_al, exp_vi;
  logic [NG*PW-1:0] exp_pt;

  task automatic compare(input string tag);
    checks++;
    if (aligned_o !== exp_al || viol_o !== exp_vi || viol_port_o !== exp_pt) begin
      errors++;
      $display("FAIL %s: aligned=%h/%h viol=%h/%h port=%h/%h (actual/expected) cycle %0d",
               tag, aligned_o, exp_al, viol_o, exp_vi, viol_port_o, exp_pt, now);
    end
  endtask

  // behavioural reference: timestamps of unmatched starts per group
  task automatic model(input logic mode, input logic [NP-1:0] st);
    exp_al = '0; exp_vi = '0; exp_pt = '0;
    for (int g = 0; g < NG; g++) begin
      logic m, s;
      m = st[g]; s = st[g+NG];
      if (!mode) begin
        m_t[g] = NONE; s_t[g] = NONE;
        continue;
      end
      if (m_t[g] == now - 1) begin
        if (s) begin exp_al[g] = 1'b1; s = 1'b0; end
        else begin exp_vi[g] = 1'b1; exp_pt[g*PW +: PW] = PW'(g + NG); end
      end else if (s_t[g] == now - 1) begin
        if (m) begin exp_al[g] = 1'b1; m = 1'b0; end
        else begin exp_vi[g] = 1'b1; exp_pt[g*PW +: PW] = PW'(g); end
      end
      m_t[g] = NONE; s_t[g] = NONE;
      if (m && s) exp_al[g] = 1'b1;
      else if (m) m_t[g] = now;
      else if (s) s_t[g] = now;
    end
  endtask

  task automatic cyc(input logic mode, input logic [NP-1:0] st, input string tag);
    pair_mode_i = mode;
    start_i     = st;
    model(mode, st);
    @(negedge clk_i);
    now++;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, '0, tag);
  endtask

  function automatic logic [NP-1:0] bits(input int a, input int b);
    logic [NP-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int g = 0; g < NG; g++) begin m_t[g] = NONE; s_t[g] = NONE; end
    exp_al = '0; exp_vi = '0; exp_pt = '0;
    repeat (2) @(negedge clk_i);
    compare("R10 reset state");
    rst_ni = 1'b1;

    // R1: unpaired mode ignores every strobe pattern
    cyc(1'b0, 16'h0101, "R1 pair in mode0");
    cyc(1'b0, 16'h0002, "R1 lone in mode0");
    cyc(1'b0, 16'hFFFF, "R1 all in mode0");
    cyc(1'b0, 16'h0000, "R1 mode0 idle");
    cyc(1'b0, 16'h0000, "R1 mode0 idle");

    // R3/R4/R5 legal skews on separate groups
    cyc(1'b1, bits(0, 8), "R3 same cycle");
    idle(2, "R3 result");
    cyc(1'b1, bits(1, -1), "R4 master first");
    cyc(1'b1, bits(9, -1), "R4 slave +1");
    idle(2, "R4 result");
    cyc(1'b1, bits(10, -1), "R5 slave first");
    cyc(1'b1, bits(2, -1), "R5 master +1");
    idle(2, "R5 result");

    // R6/R7 timeouts and skew 2
    cyc(1'b1, bits(3, -1), "R6 lone master");
    idle(3, "R6 timeout");
    cyc(1'b1, bits(12, -1), "R7 lone slave");
    idle(3, "R7 timeout");
    cyc(1'b1, bits(5, -1), "R6 skew2 master");
    cyc(1'b1, '0, "R6 skew2 gap");
    cyc(1'b1, bits(13, -1), "R6 skew2 slave");
    idle(3, "R7 skew2 stray slave");

    // R2: non-paired ports never match
    cyc(1'b1, bits(0, 1), "R2 cross ports");
    idle(3, "R2 result");
    cyc(1'b1, bits(8, 9), "R2 two slaves");
    idle(3, "R2 result slaves");

    // R11: consumption and reopening
    cyc(1'b1, bits(6, -1), "R11 master a");
    cyc(1'b1, bits(6, 14), "R11 slave+master b");
    idle(3, "R11 master b timeout");
    cyc(1'b1, bits(15, -1), "R11 slave a");
    cyc(1'b1, bits(7, 15), "R11 master+slave b");
    idle(3, "R11 slave b timeout");

    // R9: all groups at once with mixed events
    cyc(1'b1, 16'h01F0 | 16'h000F, "R9 mixed");
    cyc(1'b1, 16'hF200, "R9 mixed 2");
    idle(3, "R9 result");
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(i % 97 > 5, lfsr & {lfsr[7:0], lfsr[15:8]}, "R9 random");
    end
    idle(3, "R9 drain");

    // R10: reset with a held start
    cyc(1'b1, bits(4, -1), "R10 pending master");
    rst_ni = 1'b0;
    for (int g = 0; g < NG; g++) begin m_t[g] = NONE; s_t[g] = NONE; end
    start_i = '0;
    exp_al = '0; exp_vi = '0; exp_pt = '0;
    #1;
    compare("R10 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(4, "R10 no stale decision");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule